// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects eight interrupt request lines, latches a rising edge on each of them, masks them one by one and ranks the survivors. When a pending request outranks everything already being serviced, it raises a single interrupt line towards the processor. The processor then runs a handshake of two acknowledge pulses. The first pulse moves the winning request from the pending set to the in-service set. The second pulse returns an 8-bit vector that locates the handler.

Software programs the block through a small register port: an 8-bit data bus, one address bit, chip select, and active-low read and write strobes. It also has an active-low acknowledge strobe. All strobes are sampled on the rising clock edge, and each low cycle counts as one access. A byte sequence configures the block: a start byte, a base byte, an optional ignored byte and an optional option byte. Once configured, the block accepts run-time commands. These set the mask, end a service (specific or non-specific, with or without rotation), fix the lowest-priority level, and pick which register a status read returns.

The design has two state machines. The configuration sequencer has the states `S_UNINIT`, `S_W2`, `S_W3`, `S_W4` and `S_READY`, with these transitions:
- start byte: any state → `S_W2`
- base byte: `S_W2` → `S_W3` when the start byte asked for the spare byte, else → `S_W4` when it asked for the option byte, else → `S_READY`
- spare byte: `S_W3` → `S_W4` when the option byte was asked for, else → `S_READY`
- option byte: `S_W4` → `S_READY`

The acknowledge sequencer has the states `A_IDLE` and `A_VEC`:
- first pulse: `A_IDLE` → `A_VEC`
- second pulse: `A_VEC` → `A_IDLE`
- start byte: any state → `A_IDLE`

Top module: `prio_intc`

## Requirements
- R1: A low-to-high change on request input i sets bit i of the pending register at the next clock edge, whether or not input i is masked. The bit stays set until an acknowledge takes it.
- R2: `irq_out` is high only when the block is configured and some unmasked pending request ranks strictly above every in-service level (fully nested). It is low after reset.
- R3: A first acknowledge pulse sets the in-service bit of the highest-ranked unmasked pending request and clears that pending bit. `dout_en` stays low during this pulse.
- R4: During a second acknowledge pulse, `dout_en` is high and `dout` carries the upper five bits of the base byte in bits 7:3 and the serviced level in bits 2:0.
- R5: With automatic end of service on, the second pulse clears the serviced in-service bit. With it off, the bit stays set until an end-of-service command clears it.
- R6: A write with `a0`=0 and `din[4]`=1 is the start byte. In that byte, `din[0]`=1 requests an option byte and `din[1]`=0 requests a spare byte. The following `a0`=1 writes are taken, in order, as the base byte, then the spare byte if requested (its content is ignored), then the option byte if requested. Only after those are `a0`=1 writes taken as mask writes.
- R7: The start byte clears the mask, pending and in-service registers and sets level 7 lowest. It re-arms the edge detectors, so an input already high needs a new rising edge. It selects the pending register for status reads and turns automatic end of service off. Bit 1 of the option byte turns automatic end of service on.
- R8: Once configured, an `a0`=1 write loads the mask register. A request whose mask bit is 1 never raises `irq_out`.
- R9: A configured write with `a0`=0 and `din[4:3]`=00 is a service command, decoded by `din[7:5]`. Code 001 clears the highest-ranked in-service bit. Code 011 clears the in-service bit named by `din[2:0]`.
- R10: Command code 101 clears the highest-ranked in-service bit and makes that level lowest. Code 111 clears level `din[2:0]` and makes it lowest. Code 110 makes level `din[2:0]` lowest. Priority then runs upward from the level after the lowest, wrapping round.
- R11: A write with `a0`=0, `din[4:3]`=01 and `din[1]`=1 selects the status source: `din[0]`=0 selects the pending register and `din[0]`=1 selects the in-service register. A read with `a0`=0 returns the selected register, and a read with `a0`=1 returns the mask.
- R12: Command code 100 enables, and code 000 disables, rotation under automatic end of service. When it is enabled, each second acknowledge pulse makes the serviced level lowest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| a0 | input | 1 | Register address bit |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or vector |
| dout_en | output | 1 | High while `dout` carries valid data |
| ack_n | input | 1 | Acknowledge strobe, active low |
| irq_in | input | 8 | Request inputs |
| irq_out | output | 1 | Interrupt to the processor |

## Verification
Register reads and the vector are combinational. The bench samples them one nanosecond after it lowers the strobe, inside the same low phase, before the edge that ends the access. Writes, acknowledge pulses and request edges take effect at the first rising edge after they are driven. So the pending, in-service and mask contents, and `irq_out`, are checked from the next falling edge onward, exactly one edge later. Each bench task drives on a falling edge, holds for one full period and returns on the next falling edge, so every check falls in the cycle the register count predicts.

// File: rtl/intc_pkg.sv
package intc_pkg;

    typedef enum logic [2:0] {
        S_UNINIT,
        S_W2,
        S_W3,
        S_W4,
        S_READY
    } init_st_t;

    typedef enum logic {
        A_IDLE,
        A_VEC
    } ack_st_t;

    // service command codes carried in din[7:5]
    localparam logic [2:0] CMD_ROT_OFF  = 3'b000;
    localparam logic [2:0] CMD_EOI_NS   = 3'b001;
    localparam logic [2:0] CMD_EOI_SP   = 3'b011;
    localparam logic [2:0] CMD_ROT_ON   = 3'b100;
    localparam logic [2:0] CMD_ROT_NS   = 3'b101;
    localparam logic [2:0] CMD_SET_LOW  = 3'b110;
    localparam logic [2:0] CMD_ROT_SP   = 3'b111;

endpackage

// File: rtl/intc_edge_irr.sv
module intc_edge_irr #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rearm,
    input  logic [N-1:0] req,
    input  logic [N-1:0] take,
    output logic [N-1:0] irr
);
    logic [N-1:0] prev;

    always_ff @(posedge clk) begin
        if (!rst_n || rearm) begin
            prev <= '1;
            irr  <= '0;
        end else begin
            prev <= req;
            irr  <= (irr & ~take) | (req & ~prev);
        end
    end
endmodule

// File: rtl/intc_resolver.sv
module intc_resolver #(
    parameter int LVL_W = 3,
    localparam int N    = 1 << LVL_W
) (
    input  logic [N-1:0]     vec,
    input  logic [LVL_W-1:0] lowest,
    output logic             hit,
    output logic [LVL_W-1:0] level,
    output logic [LVL_W-1:0] rank
);
    logic [LVL_W-1:0] idx;

    // rank 0 is the level just after the lowest one; scan from the
    // worst rank down so the best hit is assigned last
    always_comb begin
        hit   = 1'b0;
        level = '0;
        rank  = '1;
        idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            idx = lowest + LVL_W'(1) + LVL_W'(k);
            if (vec[idx]) begin
                hit   = 1'b1;
                level = idx;
                rank  = LVL_W'(k);
            end
        end
    end
endmodule

// File: rtl/prio_intc.sv
module prio_intc #(
    parameter int LVL_W = 3,
    parameter int DW    = 8,
    localparam int N    = 1 << LVL_W,
    localparam int BW   = DW - LVL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          wr_n,
    input  logic          rd_n,
    input  logic          a0,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    input  logic          ack_n,
    input  logic [N-1:0]  irq_in,
    output logic          irq_out
);
    import intc_pkg::*;

    init_st_t init_st, init_nx;
    ack_st_t  ack_st, ack_nx;

    logic             need_w4, need_w3, aeoi, auto_rot, sel_isr;
    logic [BW-1:0]    base;
    logic [N-1:0]     mask, isr, isr_nx, irr, take;
    logic [LVL_W-1:0] lowest, lowest_nx, vec_lvl;

    logic             req_hit, isr_hit;
    logic [LVL_W-1:0] req_lvl, req_rank, isr_lvl, isr_rank;

    // access decode
    logic wr_ev, rd_ev, ack_ev, start_wr, ready, cmd_wr, sel_wr;
    logic first_ack, second_ack;
    logic [LVL_W-1:0] cmd_lvl;

    assign wr_ev      = !cs_n && !wr_n;
    assign rd_ev      = !cs_n && !rd_n;
    assign ack_ev     = !ack_n;
    assign start_wr   = wr_ev && !a0 && din[4];
    assign ready      = (init_st == S_READY);
    assign cmd_wr     = ready && wr_ev && !a0 && !din[4] && !din[3];
    assign sel_wr     = ready && wr_ev && !a0 && !din[4] && din[3];
    assign first_ack  = ack_ev && (ack_st == A_IDLE);
    assign second_ack = ack_ev && (ack_st == A_VEC);
    assign cmd_lvl    = din[LVL_W-1:0];

    intc_edge_irr #(.N(N)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .rearm (start_wr),
        .req   (irq_in),
        .take  (take),
        .irr   (irr)
    );

    intc_resolver #(.LVL_W(LVL_W)) u_req_rank (
        .vec    (irr & ~mask),
        .lowest (lowest),
        .hit    (req_hit),
        .level  (req_lvl),
        .rank   (req_rank)
    );

    intc_resolver #(.LVL_W(LVL_W)) u_isr_rank (
        .vec    (isr),
        .lowest (lowest),
        .hit    (isr_hit),
        .level  (isr_lvl),
        .rank   (isr_rank)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_st <= S_UNINIT;
            ack_st  <= A_IDLE;
        end else begin
            init_st <= init_nx;
            ack_st  <= ack_nx;
        end
    end

    // next state
    always_comb begin
        init_nx = init_st;
        if (start_wr) begin
            init_nx = S_W2;
        end else if (wr_ev && a0) begin
            unique case (init_st)
                S_UNINIT: init_nx = S_UNINIT;
                S_W2:     init_nx = need_w3 ? S_W3 : (need_w4 ? S_W4 : S_READY);
                S_W3:     init_nx = need_w4 ? S_W4 : S_READY;
                S_W4:     init_nx = S_READY;
                S_READY:  init_nx = S_READY;
                default:  init_nx = S_UNINIT;
            endcase
        end

        ack_nx = ack_st;
        if (start_wr) begin
            ack_nx = A_IDLE;
        end else if (ack_ev) begin
            unique case (ack_st)
                A_IDLE:  ack_nx = A_VEC;
                A_VEC:   ack_nx = A_IDLE;
                default: ack_nx = A_IDLE;
            endcase
        end
    end

    // in-service and priority update
    always_comb begin
        isr_nx    = isr;
        lowest_nx = lowest;
        take      = '0;
        if (first_ack && req_hit) begin
            isr_nx[req_lvl] = 1'b1;
            take[req_lvl]   = 1'b1;
        end
        if (second_ack && aeoi) begin
            isr_nx[vec_lvl] = 1'b0;
            if (auto_rot) lowest_nx = vec_lvl;
        end
        if (cmd_wr) begin
            unique case (din[7:5])
                CMD_EOI_NS: if (isr_hit) isr_nx[isr_lvl] = 1'b0;
                CMD_EOI_SP: isr_nx[cmd_lvl] = 1'b0;
                CMD_ROT_NS: if (isr_hit) begin
                    isr_nx[isr_lvl] = 1'b0;
                    lowest_nx       = isr_lvl;
                end
                CMD_ROT_SP: begin
                    isr_nx[cmd_lvl] = 1'b0;
                    lowest_nx       = cmd_lvl;
                end
                CMD_SET_LOW: lowest_nx = cmd_lvl;
                default: ;
            endcase
        end
        if (start_wr) begin
            isr_nx    = '0;
            lowest_nx = '1;
        end
    end

    // configuration and data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            need_w4  <= 1'b0;
            need_w3  <= 1'b0;
            aeoi     <= 1'b0;
            auto_rot <= 1'b0;
            sel_isr  <= 1'b0;
            base     <= '0;
            mask     <= '0;
            isr      <= '0;
            lowest   <= '1;
            vec_lvl  <= '1;
        end else begin
            isr    <= isr_nx;
            lowest <= lowest_nx;
            if (first_ack) vec_lvl <= req_hit ? req_lvl : '1;
            if (start_wr) begin
                need_w4  <= din[0];
                need_w3  <= !din[1];
                aeoi     <= 1'b0;
                auto_rot <= 1'b0;
                sel_isr  <= 1'b0;
                mask     <= '0;
            end else begin
                if (wr_ev && a0) begin
                    unique case (init_st)
                        S_W2:    base <= din[DW-1:LVL_W];
                        S_W4:    aeoi <= din[1];
                        S_READY: mask <= din[N-1:0];
                        default: ;
                    endcase
                end
                if (cmd_wr && din[7:5] == CMD_ROT_ON)  auto_rot <= 1'b1;
                if (cmd_wr && din[7:5] == CMD_ROT_OFF) auto_rot <= 1'b0;
                if (sel_wr && din[1]) sel_isr <= din[0];
            end
        end
    end

    // outputs
    always_comb begin
        irq_out = ready && req_hit && (!isr_hit || (req_rank < isr_rank));
        dout    = '0;
        dout_en = 1'b0;
        if (second_ack) begin
            dout    = {base, vec_lvl};
            dout_en = 1'b1;
        end else if (rd_ev) begin
            dout_en = 1'b1;
            if (a0)           dout = DW'(mask);
            else if (sel_isr) dout = DW'(isr);
            else              dout = DW'(irr);
        end
    end
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
    parameter int LVL_W = 3,
    parameter int DW    = 8,
    localparam int N    = 1 << LVL_W,
    localparam int BW   = DW - LVL_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          wr_n,
    input logic          rd_n,
    input logic          a0,
    input logic [DW-1:0] din,
    input logic          ack_n,
    input logic [DW-1:0] dout,
    input logic          dout_en,
    input logic          irq_out,
    input logic          in_vec,
    input logic          ready,
    input logic          aeoi,
    input logic [BW-1:0] base,
    input logic [N-1:0]  irr,
    input logic [N-1:0]  isr,
    input logic [N-1:0]  mask
);
    a_r3_bus_quiet_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_vec && !ack_n && (cs_n || rd_n)) |-> !dout_en);

    a_r4_vector_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vec && !ack_n) |-> (dout_en && dout[DW-1:LVL_W] == base));

    a_r2_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (ready && (irr & ~mask) != '0));

    a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !wr_n && !a0 && din[4]) |=>
        (mask == '0 && irr == '0 && isr == '0 && !irq_out));

    a_r3_take_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_vec && !ack_n && (irr & ~mask) != '0 && (irr & ~mask & isr) == '0
         && (cs_n || wr_n))
        |=> ($countones(isr) == $past($countones(isr)) + 1));

    a_r5_isr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!aeoi && (cs_n || wr_n)) |=> ($countones(isr) >= $past($countones(isr))));
endmodule

bind prio_intc intc_chk #(.LVL_W(LVL_W), .DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .wr_n    (wr_n),
    .rd_n    (rd_n),
    .a0      (a0),
    .din     (din),
    .ack_n   (ack_n),
    .dout    (dout),
    .dout_en (dout_en),
    .irq_out (irq_out),
    .in_vec  (ack_st == intc_pkg::A_VEC),
    .ready   (init_st == intc_pkg::S_READY),
    .aeoi    (aeoi),
    .base    (base),
    .irr     (irr),
    .isr     (isr),
    .mask    (mask)
);

// File: tb/prio_intc_test.sv
`timescale 1ns/1ps
module prio_intc_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, a0 = 1'b0, ack_n = 1'b1;
    logic [7:0] din = '0, irq_in = '0;
    logic [7:0] dout;
    logic       dout_en, irq_out;
    int         checks = 0, fails = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    prio_intc uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .a0(a0), .din(din), .dout(dout), .dout_en(dout_en), .ack_n(ack_n),
        .irq_in(irq_in), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk); cs_n = 0; wr_n = 0; a0 = a; din = d;
        @(negedge clk); cs_n = 1; wr_n = 1;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk); cs_n = 0; rd_n = 0; a0 = a;
        #1 d = dout;
        @(negedge clk); cs_n = 1; rd_n = 1;
    endtask

    task automatic rd_pend(output logic [7:0] d);
        wr(0, 8'h0A); rd(0, d);
    endtask

    task automatic rd_serv(output logic [7:0] d);
        wr(0, 8'h0B); rd(0, d);
    endtask

    task automatic pulse(output logic [7:0] d, output logic en);
        @(negedge clk); ack_n = 0;
        #1 d = dout; en = dout_en;
        @(negedge clk); ack_n = 1;
    endtask

    task automatic serve(input string tag, input logic [7:0] exp_vec);
        logic [7:0] d; logic en;
        pulse(d, en); chk("R3 first pulse leaves bus idle", {7'b0, en}, 8'h00);
        pulse(d, en); chk({tag, " vector"}, d, exp_vec);
        chk("R4 vector enable", {7'b0, en}, 8'h01);
    endtask

    task automatic set_lines(input logic [7:0] v);
        @(negedge clk); irq_in = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R2 irq low after reset", {7'b0, irq_out}, 8'h00);
        chk("R4 bus idle after reset", {7'b0, dout_en}, 8'h00);
    endtask

    task automatic t_init_four();
        logic [7:0] v;
        wr(0, 8'h13); wr(1, 8'h40); wr(1, 8'h00);
        rd(1, v);     chk("R7 mask cleared", v, 8'h00);
        rd_pend(v);   chk("R7 pending cleared", v, 8'h00);
    endtask

    task automatic t_single();
        logic [7:0] d; logic en;
        set_lines(8'h08);
        chk("R2 irq for lone request", {7'b0, irq_out}, 8'h01);
        rd_pend(d);  chk("R1 pending bit 3", d, 8'h08);
        pulse(d, en); chk("R3 bus idle on first pulse", {7'b0, en}, 8'h00);
        rd_serv(d);  chk("R3 in-service bit 3", d, 8'h08);
        rd_pend(d);  chk("R3 pending bit taken", d, 8'h00);
        pulse(d, en); chk("R4 vector level 3", d, 8'h43);
        rd_serv(d);  chk("R5 bit held without auto end", d, 8'h08);
        set_lines(8'h00);
    endtask

    task automatic t_nested();
        logic [7:0] d;
        set_lines(8'h20);
        chk("R2 lower level blocked", {7'b0, irq_out}, 8'h00);
        set_lines(8'h22);
        chk("R2 higher level passes", {7'b0, irq_out}, 8'h01);
        serve("R4 nested", 8'h41);
        rd_serv(d);  chk("R3 two levels in service", d, 8'h0A);
        wr(0, 8'h20);
        rd_serv(d);  chk("R9 non-specific clears best", d, 8'h08);
        chk("R2 level 5 still blocked", {7'b0, irq_out}, 8'h00);
        wr(0, 8'h63);
        rd_serv(d);  chk("R9 specific clears level 3", d, 8'h00);
        chk("R2 level 5 now passes", {7'b0, irq_out}, 8'h01);
        serve("R4 level 5", 8'h45);
        wr(0, 8'h20);
        set_lines(8'h00);
    endtask

    task automatic t_mask();
        logic [7:0] d;
        wr(1, 8'h04);
        rd(1, d);    chk("R11 mask readback", d, 8'h04);
        set_lines(8'h04);
        chk("R8 masked request silent", {7'b0, irq_out}, 8'h00);
        rd_pend(d);  chk("R1 masked edge still latched", d, 8'h04);
        wr(1, 8'h00);
        chk("R8 unmask raises irq", {7'b0, irq_out}, 8'h01);
        serve("R8 after unmask", 8'h42);
        wr(0, 8'h20);
        set_lines(8'h00);
    endtask

    task automatic t_rotate();
        set_lines(8'h10);
        serve("R10 level 4", 8'h44);
        wr(0, 8'hA0);
        set_lines(8'h48);
        serve("R10 after rotation 6 beats 3", 8'h46);
        chk("R10 level 3 ranks below 6", {7'b0, irq_out}, 8'h00);
        wr(0, 8'h20);
        chk("R9 level 3 released", {7'b0, irq_out}, 8'h01);
        serve("R10 level 3", 8'h43);
        wr(0, 8'h20);
        set_lines(8'h00);
        wr(0, 8'hC2);
        set_lines(8'h0A);
        serve("R10 set lowest 2, 3 beats 1", 8'h43);
        chk("R10 level 1 below 3", {7'b0, irq_out}, 8'h00);
        wr(0, 8'h20);
        serve("R10 level 1", 8'h41);
        wr(0, 8'h20);
        wr(0, 8'hC7);
        set_lines(8'h00);
    endtask

    task automatic t_reinit_auto();
        logic [7:0] d;
        wr(1, 8'h80);
        set_lines(8'h04);
        wr(0, 8'h11); wr(1, 8'h80); wr(1, 8'h00); wr(1, 8'h02);
        rd(1, d);    chk("R6 four bytes consumed, mask clear", d, 8'h00);
        rd_pend(d);  chk("R7 held input needs new edge", d, 8'h00);
        chk("R7 no irq without edge", {7'b0, irq_out}, 8'h00);
        set_lines(8'h00);
        set_lines(8'h04);
        chk("R7 new edge raises irq", {7'b0, irq_out}, 8'h01);
        serve("R4 new base", 8'h82);
        rd_serv(d);  chk("R5 auto end clears service", d, 8'h00);
        set_lines(8'h00);
    endtask

    task automatic t_auto_rot();
        wr(0, 8'h80);
        set_lines(8'h04);
        serve("R12 level 2", 8'h82);
        set_lines(8'h0E);
        serve("R12 rotated, 3 beats 1", 8'h83);
        serve("R12 then level 1", 8'h81);
        set_lines(8'h00);
    endtask

    task automatic t_init_two();
        logic [7:0] d;
        wr(0, 8'h12); wr(1, 8'h20);
        wr(1, 8'h5A);
        rd(1, d);    chk("R6 two-byte setup then mask", d, 8'h5A);
        wr(1, 8'h00);
        set_lines(8'h01);
        serve("R6 base 0x20", 8'h20);
        rd_serv(d);  chk("R7 auto end off by default", d, 8'h01);
        set_lines(8'h00);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_init_four();
        t_single();
        t_nested();
        t_mask();
        t_rotate();
        t_reinit_auto();
        t_auto_rot();
        t_init_two();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule